// File: doc/BRIEF.md
# Four-Channel Compare Timer with Watchdog

This block is an operating-system timer for a processor subsystem. A single 32-bit up-counter advances on each cycle in which the `tick` input is high. Four compare channels each hold a 32-bit target value. When the counter steps onto a channel's target, that channel's status flag latches. The flag stays set until software clears it by writing a one to it.

Each channel drives its own interrupt line. The line is the channel's flag gated by an enable bit. Channel 3 also serves as a watchdog. Once software has armed the watchdog, a channel-3 event produces a one-cycle reset request. Software cannot disarm the watchdog; only a reset clears it.

Software reaches the block through a plain 32-bit register bus with byte addresses. The eight registers sit on word boundaries, and reads are combinational.

Top module: `match_timer`

## Requirements
- R1: After reset, every register reads zero, and `irq` and `wdog_rst` are low.
- R2: The counter increases by one on each clock edge that sees `tick` high. It holds its value when `tick` is low, and it wraps from 0xFFFFFFFF to 0.
- R3: A write to the counter (offset 0x10) loads the written value on that edge, even when `tick` is also high. Counting then continues upward from the loaded value.
- R4: Status bit i (status register at 0x14, bit i) is set on the edge at which a tick moves the counter onto the value of compare register i. Compare register i sits at offset 4*i. Loading the counter or a compare register so that the two become equal sets nothing.
- R5: A compare value that the counter has already passed produces no event until the counter wraps around and reaches it again.
- R6: Writing the status register clears each bit that is written as 1 and leaves each bit that is written as 0. If a hardware set and a software clear of the same bit fall on the same edge, the bit ends up set.
- R7: `irq[i]` is high exactly while status bit i and enable bit i are both set. The enable register is at 0x1C, bits 3..0, and bit i belongs to channel i.
- R8: Bit 0 of the watchdog register (0x18) is set by writing 1. Writing 0 leaves it unchanged, and only reset clears it.
- R9: While the watchdog bit is set, a channel-3 event drives `wdog_rst` high for exactly one cycle. The pulse starts in the cycle in which status bit 3 first reads set. With the watchdog bit clear, a channel-3 event gives no pulse.
- R10: A read returns the addressed register in the same cycle as the strobe. Unused register bits read as 0. An address that is not one of the eight word offsets (misaligned, or 0x20 and above) reads as 0, and a write to such an address changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Count enable, one step per high cycle |
| sel | input | 1 | Bus access strobe |
| wr | input | 1 | 1 = write, 0 = read |
| addr | input | 8 | Byte address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid while `sel` is high with `wr` low |
| irq | output | 4 | Per-channel interrupt lines |
| wdog_rst | output | 1 | One-cycle watchdog reset request |

## Verification
The counter is exercised with `tick` held low, with `tick` running, and with a counter load that coincides with a tick. Together these separate holding, stepping and load priority. Compare events are provoked in three ways: by counting onto a target, by loading the counter straight onto a target, and by setting a target below the current count and then wrapping the counter through 0xFFFFFFFF. The three show whether detection is edge-like and whether it is sensitive to wrap. The status clear is tried with a written-zero bit, a written-one bit, and a clear that lands on the same edge as an event, which exposes the set-over-clear priority. The watchdog is triggered by a channel-3 event both before and after it is armed, and the enable-bit order is checked by gating a single channel.

// File: rtl/match_timer.sv
module match_timer #(
  parameter int CW = 32,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          sel,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic [CW-1:0] wdata,
  output logic [CW-1:0] rdata,
  output logic [3:0]    irq,
  output logic          wdog_rst
);
  localparam int NCH = 4;

  logic [CW-1:0]  cnt_q;
  logic [CW-1:0]  match_q [NCH];
  logic [NCH-1:0] stat_q, ien_q, ev;
  logic           wden_q, wd_q;

  wire            hit    = sel && (addr[1:0] == 2'b00) && ((addr >> 5) == '0);
  wire [2:0]      idx    = addr[4:2];
  wire            wen    = hit && wr;
  wire            cnt_wr = wen && (idx == 3'd4);
  wire            st_wr  = wen && (idx == 3'd5);
  wire [CW-1:0]   cnt_inc = cnt_q + CW'(1);

  for (genvar i = 0; i < NCH; i++) begin : g_ev
    assign ev[i] = tick && !cnt_wr && (cnt_inc == match_q[i]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      for (int i = 0; i < NCH; i++) match_q[i] <= '0;
    end else begin
      if (cnt_wr)    cnt_q <= wdata;
      else if (tick) cnt_q <= cnt_inc;
      for (int i = 0; i < NCH; i++)
        if (wen && idx == 3'(i)) match_q[i] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_q <= '0;
      ien_q  <= '0;
      wden_q <= 1'b0;
      wd_q   <= 1'b0;
    end else begin
      stat_q <= (stat_q & ~(st_wr ? wdata[NCH-1:0] : '0)) | ev;
      if (wen && idx == 3'd7) ien_q <= wdata[NCH-1:0];
      if (wen && idx == 3'd6 && wdata[0]) wden_q <= 1'b1;
      wd_q <= wden_q && ev[NCH-1];
    end
  end

  always_comb begin
    rdata = '0;
    if (hit && !wr) begin
      case (idx)
        3'd0, 3'd1, 3'd2, 3'd3: rdata = match_q[idx[1:0]];
        3'd4:    rdata = cnt_q;
        3'd5:    rdata = {{(CW-NCH){1'b0}}, stat_q};
        3'd6:    rdata = {{(CW-1){1'b0}}, wden_q};
        default: rdata = {{(CW-NCH){1'b0}}, ien_q};
      endcase
    end
  end

  assign irq      = stat_q & ien_q;
  assign wdog_rst = wd_q;
endmodule

// File: rtl/match_timer_sva.sv
module match_timer_sva #(
  parameter int CW = 32,
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick,
  input logic          sel,
  input logic          wr,
  input logic [AW-1:0] addr,
  input logic [CW-1:0] wdata,
  input logic [CW-1:0] cnt,
  input logic [3:0]    stat,
  input logic          wden,
  input logic [3:0]    irq,
  input logic          wdog_rst
);
  wire cwr = sel && wr && (addr == AW'(16));
  wire swr = sel && wr && (addr == AW'(20));

  a_r2_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !cwr) |=> (cnt == $past(cnt) + CW'(1)));
  a_r2_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !cwr) |=> $stable(cnt));
  a_r3_load: assert property (@(posedge clk) disable iff (!rst_n)
    cwr |=> (cnt == $past(wdata)));
  a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !swr |=> (($past(stat) & ~stat) == 4'b0));
  a_r7_irq_needs_status: assert property (@(posedge clk) disable iff (!rst_n)
    ((irq & ~stat) == 4'b0));
  a_r8_wden_hold: assert property (@(posedge clk) disable iff (!rst_n)
    wden |=> wden);
  a_r9_pulse_status: assert property (@(posedge clk) disable iff (!rst_n)
    wdog_rst |-> (stat[3] && wden));
  a_r9_single: assert property (@(posedge clk) disable iff (!rst_n)
    wdog_rst |=> !wdog_rst);
endmodule

bind match_timer match_timer_sva #(.CW(CW), .AW(AW)) chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .sel(sel), .wr(wr), .addr(addr),
  .wdata(wdata), .cnt(cnt_q), .stat(stat_q), .wden(wden_q), .irq(irq),
  .wdog_rst(wdog_rst)
);

// File: tb/match_timer_test.sv
module match_timer_test;
  logic        clk = 0, rst_n = 0, tick = 0, sel = 0, wr = 0;
  logic [7:0]  addr = 0;
  logic [31:0] wdata = 0;
  logic [31:0] rdata;
  logic [3:0]  irq;
  logic        wdog_rst;

  int errors = 0, checks = 0;

  logic [31:0] m_cnt;
  logic [31:0] m_match [4];
  logic [3:0]  m_stat, m_ien;
  logic        m_wden, m_wd;

  match_timer uut (.clk(clk), .rst_n(rst_n), .tick(tick), .sel(sel), .wr(wr),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq), .wdog_rst(wdog_rst));

  always #4 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_cnt = 0; m_stat = 0; m_ien = 0; m_wden = 0; m_wd = 0;
    for (int i = 0; i < 4; i++) m_match[i] = 0;
  endtask

  task automatic model_step(input logic s, w, input logic [7:0] a,
                            input logic [31:0] d, input logic t);
    logic mw;
    logic [3:0] e;
    logic [31:0] nxt;
    mw = s && w && a[1:0] == 2'b00 && a < 8'h20;
    nxt = m_cnt + 1;
    e = 0;
    for (int i = 0; i < 4; i++)
      if (t && !(mw && a == 8'h10) && nxt == m_match[i]) e[i] = 1;
    m_wd = m_wden && e[3];
    if (mw && a == 8'h10) m_cnt = d; else if (t) m_cnt = nxt;
    for (int i = 0; i < 4; i++) if (mw && a == 8'(4*i)) m_match[i] = d;
    if (mw && a == 8'h14) m_stat = m_stat & ~d[3:0];
    m_stat = m_stat | e;
    if (mw && a == 8'h1C) m_ien = d[3:0];
    if (mw && a == 8'h18 && d[0]) m_wden = 1;
  endtask

  function automatic logic [31:0] mread(input logic [7:0] a);
    if (a[1:0] != 0 || a >= 8'h20) return 0;
    case (a)
      8'h10: return m_cnt;
      8'h14: return {28'b0, m_stat};
      8'h18: return {31'b0, m_wden};
      8'h1C: return {28'b0, m_ien};
      default: return m_match[a[3:2]];
    endcase
  endfunction

  task automatic cyc(input logic s, w, input logic [7:0] a, input logic [31:0] d, input logic t);
    sel = s; wr = w; addr = a; wdata = d; tick = t;
    @(posedge clk);
    model_step(s, w, a, d, t);
    @(negedge clk);
    check("R7 irq vs model", {28'b0, irq}, {28'b0, m_stat & m_ien});
    check("R9 wdog_rst vs model", {31'b0, wdog_rst}, {31'b0, m_wd});
  endtask

  task automatic wrr(input logic [7:0] a, input logic [31:0] d, input logic t = 0);
    cyc(1, 1, a, d, t);
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    sel = 1; wr = 0; addr = a; tick = 0;
    #1;
    check(tag, rdata, exp);
    cyc(1, 0, a, 0, 0);
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) cyc(0, 0, 0, 0, 1);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: run did not finish");
    finish_run();
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    check("R1 irq after reset", {28'b0, irq}, 0);
    check("R1 wdog_rst after reset", {31'b0, wdog_rst}, 0);
    for (int a = 0; a < 32; a += 4) rd(8'(a), 0, "R1 register reset value");

    cyc(0, 0, 0, 0, 0); cyc(0, 0, 0, 0, 0);
    rd(8'h10, 0, "R2 hold without tick");
    ticks(5);
    rd(8'h10, 5, "R2 count on tick");

    wrr(8'h10, 100, 1);
    rd(8'h10, 100, "R3 load beats tick");
    ticks(3);
    rd(8'h10, 103, "R3 count continues from load");

    wrr(8'h00, 110);
    wrr(8'h1C, 1);
    ticks(6);
    rd(8'h14, 0, "R4 no event before target");
    ticks(1);
    check("R7 irq0 on event", {28'b0, irq}, 1);
    rd(8'h14, 1, "R4 status set on reaching target");

    wrr(8'h14, 0);
    rd(8'h14, 1, "R6 written zero keeps bit");
    wrr(8'h14, 1);
    rd(8'h14, 0, "R6 written one clears bit");
    check("R7 irq drops after clear", {28'b0, irq}, 0);

    wrr(8'h04, 200);
    wrr(8'h10, 200);
    ticks(1);
    rd(8'h14, 0, "R4 load onto target sets nothing");

    wrr(8'h08, 150);
    ticks(10);
    rd(8'h14, 0, "R5 passed target does not fire");
    wrr(8'h10, 32'hFFFF_FFFE);
    ticks(2);
    rd(8'h10, 0, "R2 wrap to zero");
    rd(8'h14, 8, "R9 ch3 event while unarmed");
    ticks(150);
    rd(8'h14, 32'hD, "R5 passed target fires after wrap");

    wrr(8'h14, 32'hF);
    wrr(8'h10, 109);
    cyc(1, 1, 8'h14, 1, 1);
    rd(8'h14, 1, "R6 set wins over clear");

    wrr(8'h1C, 4);
    check("R7 ch0 gated off", {28'b0, irq}, 0);
    wrr(8'h10, 149);
    ticks(1);
    check("R7 enable bit order", {28'b0, irq}, 4);

    wrr(8'h18, 0);
    rd(8'h18, 0, "R8 zero write does not arm");
    wrr(8'h18, 1);
    rd(8'h18, 1, "R8 one write arms");
    wrr(8'h18, 0);
    rd(8'h18, 1, "R8 zero write cannot disarm");

    wrr(8'h0C, 500);
    wrr(8'h10, 498);
    ticks(1);
    check("R9 no pulse before event", {31'b0, wdog_rst}, 0);
    ticks(1);
    check("R9 pulse on ch3 event", {31'b0, wdog_rst}, 1);
    rd(8'h14, 32'hD, "R9 status3 with pulse");
    check("R9 pulse lasts one cycle", {31'b0, wdog_rst}, 0);

    wrr(8'h20, 32'hFFFF_FFFF);
    wrr(8'h1D, 32'hF);
    wrr(8'h15, 32'hF);
    wrr(8'h11, 32'h1234);
    rd(8'h00, 110, "R10 write at 0x20 ignored");
    rd(8'h1C, 4, "R10 misaligned enable write ignored");
    rd(8'h14, 32'hD, "R10 misaligned status write ignored");
    rd(8'h10, mread(8'h10), "R10 misaligned counter write ignored");
    rd(8'h24, 0, "R10 unmapped read is zero");
    rd(8'h13, 0, "R10 misaligned read is zero");
    for (int a = 0; a < 32; a += 4) rd(8'(a), mread(8'(a)), "R10 register map");

    finish_run();
  end
endmodule